// File: doc/BRIEF.md
# Misaligned Access Exception Unit

This block sits between the data address generators of a small processor pipeline and its data memory port. Every cycle each generator slot may present one load or store request, which carries an access size and a byte address. The unit lets aligned requests through to memory unchanged. It blocks any request whose address does not suit its size, so the request never reaches the memory port.

When a request is blocked, the unit raises a synchronous exception pulse on the next cycle. In that same cycle it loads three registers. The status register receives a fixed cause code. The fault-address register receives the exact offending byte address. The return-address register receives the program counter of the instruction that made the access. Software can write the fault-address register directly, for example to set it to a known value before a test.

The exception vector fetch, the privilege handling and the memory array are outside this block.

Top module: `misalign_guard`

## Requirements
- R1: A request with size code 01 (16-bit) whose address bit 0 is 1 is misaligned. It is blocked: mem_valid for its slot is low in the same cycle.
- R2: A request with size code 10 (32-bit) whose address bits [1:0] are 01, 10 or 11 is misaligned and blocked in the same cycle.
- R3: Requests with size code 00 (8-bit) are never blocked, at any address. The reserved code 11 is also never blocked. Aligned 16-bit and 32-bit requests pass as well. None of these pulses the exception or changes any captured register.
- R4: Loads (req_write=0) and stores (req_write=1) are checked alike. A blocked store drives mem_we low for its slot. A blocked load drives ld_wb_en low. A passing store drives mem_we high, and a passing load drives ld_wb_en high.
- R5: Every slot is checked with the same rule, including slot 1 when it is issued alongside slot 0.
- R6: On a fault the status register exc_cause is loaded with the cause code 0x24. It holds that value until reset.
- R7: On a fault, fault_addr receives the full unrounded byte address of the faulting request.
- R8: On a fault, ret_pc receives the req_pc presented with the faulting request.
- R9: If several slots fault in the same cycle, the lowest-numbered slot wins, and its address is the one recorded in fault_addr.
- R10: exc_pulse is high for exactly the cycle after each cycle that has a fault. exc_cause, fault_addr and ret_pc take their new values in that same cycle.
- R11: When fa_wr_en is high, fault_addr loads fa_wr_data on the next cycle. Otherwise fault_addr holds until the next fault. If a fault and a write occur in the same cycle, the fault address wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NSLOT | Request present, one bit per slot |
| req_write | input | NSLOT | 1 = store, 0 = load, per slot |
| req_size | input | 2*NSLOT | Size code per slot (00 byte, 01 half, 10 word, 11 reserved) |
| req_addr | input | ADDR_W*NSLOT | Byte address per slot, slot 0 in the low bits |
| req_pc | input | PC_W | Address of the issuing instruction |
| fa_wr_en | input | 1 | Software write strobe for the fault-address register |
| fa_wr_data | input | ADDR_W | Value written by software |
| mem_valid | output | NSLOT | Request forwarded to memory |
| mem_we | output | NSLOT | Memory write enable |
| ld_wb_en | output | NSLOT | Load destination update enable |
| exc_pulse | output | 1 | Alignment exception, one cycle after the fault |
| exc_cause | output | CAUSE_W | Status register cause field |
| fault_addr | output | ADDR_W | Captured faulting byte address |
| ret_pc | output | PC_W | Captured instruction address |

## Verification
The bench builds the unit with its default parameters: two slots, 32-bit addresses and program counters, and a 6-bit cause field holding 0x24. With two slots, both slots can fault together, which exercises the slot priority. The 32-bit address lets the bench check every low-bit pattern of both access sizes next to high address bits that must be kept unrounded. The scoreboard also covers a software write to the fault-address register that lands in the same cycle as a fault.

// File: rtl/mag_pkg.sv
package mag_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } acc_size_e;

   // Alignment rule on the two low address bits
   function automatic logic is_misaligned(input logic [1:0] size, input logic [1:0] lo);
      logic bad;
      case (acc_size_e'(size))
         SZ_HALF: bad = lo[0];
         SZ_WORD: bad = (lo != 2'b00);
         default: bad = 1'b0;
      endcase
      return bad;
   endfunction

endpackage

// File: rtl/mag_align_check.sv
module mag_align_check
   import mag_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              valid,
   input  logic [1:0]        size,
   input  logic [ADDR_W-1:0] addr,
   output logic              fault
);
   localparam int LOW_BITS = 2;

   logic [LOW_BITS-1:0] lo;
   assign lo    = addr[LOW_BITS-1:0];
   assign fault = valid & is_misaligned(size, lo);
endmodule

// File: rtl/mag_fault_pick.sv
module mag_fault_pick #(
   parameter int NSLOT  = 2,
   parameter int ADDR_W = 32
) (
   input  logic [NSLOT-1:0]        fault,
   input  logic [ADDR_W*NSLOT-1:0] addr_flat,
   output logic                    any_fault,
   output logic [ADDR_W-1:0]       sel_addr
);
   assign any_fault = |fault;

   // Scan from the highest slot downward so the lowest faulting slot is the last one assigned
   always_comb begin
      sel_addr = '0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (fault[i]) sel_addr = addr_flat[i*ADDR_W +: ADDR_W];
      end
   end
endmodule

// File: rtl/mag_fault_regs.sv
module mag_fault_regs #(
   parameter int ADDR_W     = 32,
   parameter int PC_W       = 32,
   parameter int CAUSE_W    = 6,
   parameter int CAUSE_CODE = 'h24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               any_fault,
   input  logic [ADDR_W-1:0]  sel_addr,
   input  logic [PC_W-1:0]    pc,
   input  logic               sw_we,
   input  logic [ADDR_W-1:0]  sw_data,
   output logic               exc_pulse,
   output logic [CAUSE_W-1:0] cause,
   output logic [ADDR_W-1:0]  faddr,
   output logic [PC_W-1:0]    retx
);
   localparam logic [CAUSE_W-1:0] CAUSE_V = CAUSE_W'(CAUSE_CODE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exc_pulse <= 1'b0;
         cause     <= '0;
         faddr     <= '0;
         retx      <= '0;
      end else begin
         exc_pulse <= any_fault;
         if (any_fault) begin
            cause <= CAUSE_V;
            faddr <= sel_addr;
            retx  <= pc;
         end else if (sw_we) begin
            faddr <= sw_data;
         end
      end
   end
endmodule

// File: rtl/misalign_guard.sv
module misalign_guard #(
   parameter int NSLOT      = 2,
   parameter int ADDR_W     = 32,
   parameter int PC_W       = 32,
   parameter int CAUSE_W    = 6,
   parameter int CAUSE_CODE = 'h24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NSLOT-1:0]        req_valid,
   input  logic [NSLOT-1:0]        req_write,
   input  logic [2*NSLOT-1:0]      req_size,
   input  logic [ADDR_W*NSLOT-1:0] req_addr,
   input  logic [PC_W-1:0]         req_pc,
   input  logic                    fa_wr_en,
   input  logic [ADDR_W-1:0]       fa_wr_data,
   output logic [NSLOT-1:0]        mem_valid,
   output logic [NSLOT-1:0]        mem_we,
   output logic [NSLOT-1:0]        ld_wb_en,
   output logic                    exc_pulse,
   output logic [CAUSE_W-1:0]      exc_cause,
   output logic [ADDR_W-1:0]       fault_addr,
   output logic [PC_W-1:0]         ret_pc
);
   localparam int SZ_W = 2;

   // elaboration-time parameter checks
   if (NSLOT < 1) begin : g_bad_nslot
      $error("misalign_guard: NSLOT must be at least 1");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("misalign_guard: ADDR_W must be at least 2");
   end
   if (CAUSE_W < 1 || CAUSE_W > 31 || (CAUSE_CODE >> CAUSE_W) != 0) begin : g_bad_cause
      $error("misalign_guard: CAUSE_CODE does not fit CAUSE_W");
   end

   logic [NSLOT-1:0]  slot_fault;
   logic              any_fault;
   logic [ADDR_W-1:0] sel_addr;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      mag_align_check #(.ADDR_W(ADDR_W)) u_chk (
         .valid (req_valid[s]),
         .size  (req_size[s*SZ_W +: SZ_W]),
         .addr  (req_addr[s*ADDR_W +: ADDR_W]),
         .fault (slot_fault[s])
      );
      assign mem_valid[s] = req_valid[s] & ~slot_fault[s];
      assign mem_we[s]    = mem_valid[s] & req_write[s];
      assign ld_wb_en[s]  = mem_valid[s] & ~req_write[s];
   end

   mag_fault_pick #(.NSLOT(NSLOT), .ADDR_W(ADDR_W)) u_pick (
      .fault     (slot_fault),
      .addr_flat (req_addr),
      .any_fault (any_fault),
      .sel_addr  (sel_addr)
   );

   mag_fault_regs #(
      .ADDR_W(ADDR_W), .PC_W(PC_W), .CAUSE_W(CAUSE_W), .CAUSE_CODE(CAUSE_CODE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_fault (any_fault),
      .sel_addr  (sel_addr),
      .pc        (req_pc),
      .sw_we     (fa_wr_en),
      .sw_data   (fa_wr_data),
      .exc_pulse (exc_pulse),
      .cause     (exc_cause),
      .faddr     (fault_addr),
      .retx      (ret_pc)
   );
endmodule

// File: rtl/mag_checker.sv
module mag_checker #(
   parameter int NSLOT      = 2,
   parameter int ADDR_W     = 32,
   parameter int PC_W       = 32,
   parameter int CAUSE_W    = 6,
   parameter int CAUSE_CODE = 'h24
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NSLOT-1:0]        req_valid,
   input logic [NSLOT-1:0]        req_write,
   input logic [2*NSLOT-1:0]      req_size,
   input logic [ADDR_W*NSLOT-1:0] req_addr,
   input logic [PC_W-1:0]         req_pc,
   input logic                    fa_wr_en,
   input logic [NSLOT-1:0]        mem_valid,
   input logic [NSLOT-1:0]        mem_we,
   input logic [NSLOT-1:0]        ld_wb_en,
   input logic                    exc_pulse,
   input logic [CAUSE_W-1:0]      exc_cause,
   input logic [ADDR_W-1:0]       fault_addr,
   input logic [PC_W-1:0]         ret_pc
);
   logic [NSLOT-1:0] bad;
   logic             any_bad;

   for (genvar s = 0; s < NSLOT; s++) begin : g_c
      logic [1:0] sz;
      logic [1:0] lo;
      assign sz = req_size[2*s +: 2];
      assign lo = req_addr[s*ADDR_W +: 2];
      assign bad[s] = req_valid[s] &&
                      ((sz == 2'b01 && lo[0]) || (sz == 2'b10 && lo != 2'b00));

      // R1 R2 R5
      blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
         bad[s] |-> !mem_valid[s]);
      // R3
      byte_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid[s] && sz == 2'b00) |-> mem_valid[s]);
      // R4
      store_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         mem_we[s] |-> (req_write[s] && !bad[s] && req_valid[s]));
      // R4
      load_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ld_wb_en[s] |-> (!req_write[s] && !bad[s] && req_valid[s]));
   end

   assign any_bad = |bad;

   // R10
   pulse_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_bad |=> exc_pulse);
   // R10
   pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_pulse |-> $past(any_bad));
   // R6
   cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_pulse |-> exc_cause == CAUSE_W'(CAUSE_CODE));
   // R8
   retpc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_bad |=> ret_pc == $past(req_pc));
   // R9 R7
   slot0_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad[0] |=> fault_addr == $past(req_addr[ADDR_W-1:0]));
   // R11
   faddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_bad && !fa_wr_en) |=> $stable(fault_addr));
endmodule

bind misalign_guard mag_checker #(
   .NSLOT(NSLOT), .ADDR_W(ADDR_W), .PC_W(PC_W),
   .CAUSE_W(CAUSE_W), .CAUSE_CODE(CAUSE_CODE)
) u_mag_chk (.*);

// File: tb/sim_misalign_guard.sv
`timescale 1ns/1ps
module sim_misalign_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  req_valid = '0;
   logic [1:0]  req_write = '0;
   logic [3:0]  req_size = '0;
   logic [63:0] req_addr = '0;
   logic [31:0] req_pc = '0;
   logic        fa_wr_en = 1'b0;
   logic [31:0] fa_wr_data = '0;
   logic [1:0]  mem_valid, mem_we, ld_wb_en;
   logic        exc_pulse;
   logic [5:0]  exc_cause;
   logic [31:0] fault_addr, ret_pc;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   typedef struct {
      bit          pulse;
      logic [5:0]  cause;
      logic [31:0] fa;
      logic [31:0] rp;
      string       tag;
   } exp_t;
   exp_t sb[$];

   logic [5:0]  m_cause = '0;
   logic [31:0] m_fa = '0;
   logic [31:0] m_rp = '0;

   always #10 clk = ~clk;

   misalign_guard u0 (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit mis(input logic [1:0] s, input logic [31:0] a);
      if (s == 2'b01) return a[0];
      if (s == 2'b10) return a[1:0] != 2'b00;
      return 1'b0;
   endfunction

   // driver: applies one cycle of stimulus, checks same-cycle gating, queues expected registers
   task automatic drive(input logic [1:0] v, input logic [1:0] w,
                        input logic [1:0] s0, input logic [31:0] a0,
                        input logic [1:0] s1, input logic [31:0] a1,
                        input logic [31:0] pc, input bit swe, input logic [31:0] swd,
                        input string tag);
      logic [1:0] f, emv, ewe, ewb;
      exp_t e;
      @(negedge clk);
      req_valid = v; req_write = w;
      req_size = {s1, s0}; req_addr = {a1, a0}; req_pc = pc;
      fa_wr_en = swe; fa_wr_data = swd;
      f[0] = v[0] && mis(s0, a0);
      f[1] = v[1] && mis(s1, a1);
      emv = v & ~f;
      ewe = emv & w;
      ewb = emv & ~w;
      #5;
      chk(mem_valid == emv, tag, "mem_valid", 64'(mem_valid), 64'(emv));
      chk(mem_we == ewe, tag, "mem_we", 64'(mem_we), 64'(ewe));
      chk(ld_wb_en == ewb, tag, "ld_wb_en", 64'(ld_wb_en), 64'(ewb));
      if (f != 2'b00) begin
         m_cause = 6'h24;
         m_fa = f[0] ? a0 : a1;
         m_rp = pc;
      end else if (swe) begin
         m_fa = swd;
      end
      e.pulse = (f != 2'b00);
      e.cause = m_cause; e.fa = m_fa; e.rp = m_rp; e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle(input string tag);
      drive(2'b00, 2'b00, 2'b00, 32'h0, 2'b00, 32'h0, 32'h0, 1'b0, 32'h0, tag);
   endtask

   // monitor: compares registered outputs just after each edge
   always @(posedge clk) begin
      #2;
      if (rst_n && sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         chk(exc_pulse == e.pulse, {e.tag, " R10"}, "exc_pulse", 64'(exc_pulse), 64'(e.pulse));
         chk(exc_cause == e.cause, {e.tag, " R6"}, "exc_cause", 64'(exc_cause), 64'(e.cause));
         chk(fault_addr == e.fa, {e.tag, " R7"}, "fault_addr", 64'(fault_addr), 64'(e.fa));
         chk(ret_pc == e.rp, {e.tag, " R8"}, "ret_pc", 64'(ret_pc), 64'(e.rp));
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #5;
      chk(exc_pulse == 1'b0 && exc_cause == 6'h0 && fault_addr == 32'h0 && ret_pc == 32'h0,
          "reset", "regs", {exc_cause, fault_addr[25:0]}, 64'h0);

      // R3: bytes at odd addresses, aligned half and word, reserved code
      drive(2'b01, 2'b01, 2'b00, 32'h1003, 2'b00, 32'h0, 32'h400, 0, 0, "R3 byte store");
      drive(2'b11, 2'b00, 2'b01, 32'h1002, 2'b10, 32'h2004, 32'h404, 0, 0, "R3 aligned loads");
      drive(2'b10, 2'b10, 2'b00, 32'h0, 2'b11, 32'h1003, 32'h408, 0, 0, "R3 reserved");
      // R1: half store odd, slot 0
      drive(2'b01, 2'b01, 2'b01, 32'h1001, 2'b00, 32'h0, 32'h500, 0, 0, "R1 half store");
      // R2: word stores at each misaligned offset
      drive(2'b01, 2'b01, 2'b10, 32'h1001, 2'b00, 32'h0, 32'h504, 0, 0, "R2 word+1");
      drive(2'b01, 2'b01, 2'b10, 32'h1002, 2'b00, 32'h0, 32'h508, 0, 0, "R2 word+2");
      drive(2'b01, 2'b01, 2'b10, 32'h1003, 2'b00, 32'h0, 32'h50c, 0, 0, "R2 word+3");
      idle("R3 hold");
      // R4: loads fault the same way
      drive(2'b01, 2'b00, 2'b01, 32'hABCD1001, 2'b00, 32'h0, 32'h600, 0, 0, "R4 half load");
      drive(2'b01, 2'b00, 2'b10, 32'h80001002, 2'b00, 32'h0, 32'h604, 0, 0, "R4 word load");
      // R5: slot 1, parallel with a passing slot 0
      drive(2'b11, 2'b10, 2'b00, 32'h3000, 2'b01, 32'h1001, 32'h700, 0, 0, "R5 slot1 half store");
      drive(2'b11, 2'b01, 2'b10, 32'h3004, 2'b10, 32'h1003, 32'h704, 0, 0, "R5 slot1 word load");
      // R9: both slots fault
      drive(2'b11, 2'b11, 2'b10, 32'h4002, 2'b01, 32'h5001, 32'h800, 0, 0, "R9 both fault");
      drive(2'b11, 2'b00, 2'b01, 32'h6003, 2'b10, 32'h7001, 32'h804, 0, 0, "R9 both fault loads");
      // R11: software write, hold, and fault wins over write
      drive(2'b00, 2'b00, 2'b00, 0, 2'b00, 0, 32'h900, 1, 32'h0, "R11 sw write");
      idle("R11 hold");
      drive(2'b01, 2'b01, 2'b10, 32'h1000, 2'b00, 0, 32'h904, 0, 0, "R11 hold aligned");
      drive(2'b01, 2'b00, 2'b10, 32'h1001, 2'b00, 0, 32'h908, 1, 32'h12345678, "R11 fault beats write");
      drive(2'b00, 2'b00, 2'b00, 0, 2'b00, 0, 32'h0, 1, 32'hCAFE0000, "R11 sw write 2");
      idle("R10 drain");
      idle("R10 drain");
      @(negedge clk);
      finish_run();
   end
endmodule